// File: doc/BRIEF.md
# Latched Serial-In Open-Drain Sink Driver

This block is a serial-in, parallel-out register for driving a row of common-anode LEDs. Each rising edge of the shift clock moves the serial input into the first stage and passes every stage's value on to the next. A separate bank of hold flops copies the stage contents while the latch-enable input is high, so the LED pattern stays steady while the next frame is shifted in. The last stage is brought out on a cascade pin, which lets several blocks be chained into one longer register.

Each parallel output is given as a drive-enable bit together with a driven level that is always 0. A pad wrapper outside the block turns each pair into an open-drain pin. A held 1 makes the pin sink current and light its LED. A held 0 releases the pin.

An active-low direct-set input forces every stage and every hold bit to 1 at once, with no clock needed. After direct-set is released, a fixed number of shift-clock edges are ignored for shifting. An active-high output-off input releases all parallel outputs. It has no effect on the cascade pin, on shifting or on the held pattern.

The serial path has no handshake and no back-pressure. Every rising edge outside the set and recovery window consumes one bit, so the source must present a valid bit at every edge.

Top module: `led_sink_shifter`

## Requirements
- R1: Outside direct-set and the recovery window, each rising edge of `shift_clk` loads `ser_in` into stage 1 and moves stage k into stage k+1. Stage 1 maps to bit 0 of `sink_en`.
- R2: `cascade_out` always equals the last stage, stage WIDTH.
- R3: On a rising edge with `latch_en` high, the hold bank takes the stage contents as they were just before that edge. With `latch_en` low, the hold bank keeps its value.
- R4: While `set_n` is low, every stage and every hold bit is 1 without waiting for a clock edge. `cascade_out` is then 1, and `sink_en` is all ones when `out_off` is low.
- R5: With `out_off` low, `sink_en[i]` is 1 exactly when hold bit i is 1. A 1 means the pin sinks; a 0 means it is released.
- R6: With `out_off` high, `sink_en` is all zeros, while `cascade_out` keeps following the last stage.
- R7: Toggling `out_off` changes neither the shift stages nor the hold bank.
- R8: After `set_n` rises, the first RECOVERY_EDGES rising edges do not shift. The hold bank may still load on those edges.
- R9: `sink_level` is all zeros at all times.
- R10: With two blocks chained (cascade into serial input), 2*WIDTH bits shifted in appear across both hold banks. The first bit shifted lands in stage WIDTH of the second block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock, rising edge active |
| set_n | input | 1 | Asynchronous direct set, active low |
| ser_in | input | 1 | Serial data into stage 1 |
| latch_en | input | 1 | Hold bank loads while high |
| out_off | input | 1 | Releases all parallel outputs when high |
| sink_en | output | WIDTH | Per-pin drive enable, 1 = sink |
| sink_level | output | WIDTH | Level driven when enabled, constant 0 |
| cascade_out | output | 1 | Last stage, feeds the next block |

## Verification
The hardest case to reach is the recovery window. The edges just after direct-set is released must leave the stages frozen while the hold bank still loads. To reach it, the bench releases `set_n` and then loads the hold bank during the ignored edges, so a stage that wrongly moved would show at the pins. The bench also applies direct-set in the middle of a 64-bit stream through two chained blocks, and toggles `out_off` during shifting. A queue model of the whole chain catches any lost or extra shift at the cascade and at the second block's outputs.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int unsigned LSS_DEF_WIDTH   = 32;
  localparam int unsigned LSS_DEF_RECOVER = 2;
  localparam int unsigned LSS_MIN_WIDTH   = 2;
endpackage

// File: rtl/lss_shift_chain.sv
module lss_shift_chain #(
  parameter int unsigned W = lss_pkg::LSS_DEF_WIDTH
) (
  input  logic         clk,
  input  logic         set_n,
  input  logic         adv,
  input  logic         din,
  output logic [W-1:0] stages
);
  // stage 1 is bit 0; async set forces every stage high
  always_ff @(posedge clk or negedge set_n) begin
    if (!set_n)   stages <= '1;
    else if (adv) stages <= {stages[W-2:0], din};
  end
endmodule

// File: rtl/lss_latch_bank.sv
module lss_latch_bank #(
  parameter int unsigned W = lss_pkg::LSS_DEF_WIDTH
) (
  input  logic         clk,
  input  logic         set_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // edge-loaded stand-in for a level-sensitive latch
  always_ff @(posedge clk or negedge set_n) begin
    if (!set_n)    q <= '1;
    else if (load) q <= d;
  end
endmodule

// File: rtl/lss_recovery_guard.sv
module lss_recovery_guard #(
  parameter int unsigned EDGES = lss_pkg::LSS_DEF_RECOVER
) (
  input  logic clk,
  input  logic set_n,
  output logic shift_ok
);
  generate
    if (EDGES == 0) begin : g_none
      assign shift_ok = 1'b1;
    end else begin : g_count
      localparam int unsigned CW = $clog2(EDGES + 1);
      localparam logic [CW-1:0] START = CW'(EDGES);
      logic [CW-1:0] left;
      always_ff @(posedge clk or negedge set_n) begin
        if (!set_n)         left <= START;
        else if (left != 0) left <= left - 1'b1;
      end
      assign shift_ok = (left == '0);
    end
  endgenerate
endmodule

// File: rtl/lss_sink_gate.sv
module lss_sink_gate #(
  parameter int unsigned W = lss_pkg::LSS_DEF_WIDTH
) (
  input  logic [W-1:0] held,
  input  logic         out_off,
  output logic [W-1:0] sink_en,
  output logic [W-1:0] sink_level
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign sink_en[i]    = held[i] & ~out_off;
    assign sink_level[i] = 1'b0;
  end
endmodule

// File: rtl/led_sink_shifter.sv
module led_sink_shifter #(
  parameter int unsigned WIDTH          = lss_pkg::LSS_DEF_WIDTH,
  parameter int unsigned RECOVERY_EDGES = lss_pkg::LSS_DEF_RECOVER
) (
  input  logic             shift_clk,
  input  logic             set_n,
  input  logic             ser_in,
  input  logic             latch_en,
  input  logic             out_off,
  output logic [WIDTH-1:0] sink_en,
  output logic [WIDTH-1:0] sink_level,
  output logic             cascade_out
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             shift_ok;
  logic [WIDTH-1:0] stages;
  logic [WIDTH-1:0] latched;

  lss_recovery_guard #(.EDGES(RECOVERY_EDGES)) u_guard (
    .clk(shift_clk), .set_n(set_n), .shift_ok(shift_ok)
  );

  lss_shift_chain #(.W(WIDTH)) u_chain (
    .clk(shift_clk), .set_n(set_n), .adv(shift_ok), .din(ser_in), .stages(stages)
  );

  lss_latch_bank #(.W(WIDTH)) u_hold (
    .clk(shift_clk), .set_n(set_n), .load(latch_en), .d(stages), .q(latched)
  );

  lss_sink_gate #(.W(WIDTH)) u_gate (
    .held(latched), .out_off(out_off), .sink_en(sink_en), .sink_level(sink_level)
  );

  assign cascade_out = stages[LAST];
endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
  parameter int unsigned W = lss_pkg::LSS_DEF_WIDTH
) (
  input logic         clk,
  input logic         set_n,
  input logic         ser_in,
  input logic         latch_en,
  input logic         out_off,
  input logic         shift_ok,
  input logic [W-1:0] stages,
  input logic [W-1:0] latched,
  input logic [W-1:0] sink_en,
  input logic         cascade_out
);
  a_r1_stage_one_takes_input: assert property (@(posedge clk) disable iff (!set_n)
    shift_ok |=> stages[0] == $past(ser_in));
  a_r2_cascade_follows_chain: assert property (@(posedge clk) disable iff (!set_n)
    shift_ok |=> cascade_out == $past(stages[W-2]));
  a_r3_hold_when_low: assert property (@(posedge clk) disable iff (!set_n)
    !latch_en |=> $stable(latched));
  a_r3_load_when_high: assert property (@(posedge clk) disable iff (!set_n)
    latch_en |=> latched == $past(stages));
  a_r4_set_leaves_ones: assert property (@(posedge clk) disable iff (!set_n)
    $rose(set_n) |-> (cascade_out && (&latched)));
  a_r6_off_releases_all: assert property (@(posedge clk) disable iff (!set_n)
    out_off |-> sink_en == '0);
  a_r8_recovery_freezes: assert property (@(posedge clk) disable iff (!set_n)
    !shift_ok |=> $stable(stages));
endmodule

bind led_sink_shifter lss_checker #(.W(WIDTH)) u_lss_chk (
  .clk(shift_clk), .set_n(set_n), .ser_in(ser_in), .latch_en(latch_en),
  .out_off(out_off), .shift_ok(shift_ok), .stages(stages), .latched(latched),
  .sink_en(sink_en), .cascade_out(cascade_out)
);

// File: tb/led_sink_shifter_test.sv
`timescale 1ns/1ps
module led_sink_shifter_test;
  localparam int W = 32;
  localparam int REC = 2;

  logic clk = 1'b0;
  logic set_n = 1'b0;
  logic ser_in = 1'b0, latch_en = 1'b0, out_off = 1'b0;
  logic [W-1:0] en_a, en_b, lvl_a, lvl_b;
  logic casc_a, casc_b;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  led_sink_shifter #(.WIDTH(W), .RECOVERY_EDGES(REC)) uut (
    .shift_clk(clk), .set_n(set_n), .ser_in(ser_in), .latch_en(latch_en),
    .out_off(out_off), .sink_en(en_a), .sink_level(lvl_a), .cascade_out(casc_a));
  led_sink_shifter #(.WIDTH(W), .RECOVERY_EDGES(REC)) uut_tail (
    .shift_clk(clk), .set_n(set_n), .ser_in(casc_a), .latch_en(latch_en),
    .out_off(out_off), .sink_en(en_b), .sink_level(lvl_b), .cascade_out(casc_b));

  // reference model: whole chain as a queue, index 0 = first stage
  bit chain[$];
  bit [W-1:0] ha, hb;
  int rec_left;

  initial begin
    for (int i = 0; i < 2*W; i++) chain.push_back(1'b1);
    ha = '1; hb = '1; rec_left = REC;
  end

  always @(negedge set_n) begin
    for (int i = 0; i < 2*W; i++) chain[i] = 1'b1;
    ha = '1; hb = '1; rec_left = REC;
  end

  always @(posedge clk) begin
    if (set_n) begin
      bit [W-1:0] sa, sb;
      for (int i = 0; i < W; i++) begin sa[i] = chain[i]; sb[i] = chain[W+i]; end
      if (rec_left > 0) rec_left--;
      else begin chain.push_front(ser_in); void'(chain.pop_back()); end
      if (latch_en) begin ha = sa; hb = sb; end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk("R5 sink_en head", en_a, ha & ~{W{out_off}});
    chk("R10 sink_en tail", en_b, hb & ~{W{out_off}});
    chk("R2 cascade head", casc_a, chain[W-1]);
    chk("R2 cascade tail", casc_b, chain[2*W-1]);
    chk("R9 sink_level", {lvl_a, lvl_b}, 64'h0);
  endtask

  task automatic tick(input logic s, input logic l, input logic o);
    ser_in = s; latch_en = l; out_off = o;
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] pat;
    logic [W-1:0] keep_a, keep_b;
    logic [15:0] lfsr;
    pat = 64'hA5C3_0F1E_9B72_4D68;
    lfsr = 16'hACE1;
    @(negedge clk);
    tick(0, 0, 0); tick(0, 0, 0);
    // R4 reset state via direct set
    chk("R4 set ones head", en_a, {W{1'b1}});
    chk("R4 set ones tail", en_b, {W{1'b1}});
    chk("R4 cascade high", {casc_a, casc_b}, 2'b11);
    set_n = 1'b1;
    // R8: two ignored edges while loading, hold bank stays all ones
    tick(0, 1, 0); tick(0, 1, 0);
    chk("R8 no shift in recovery", en_a, {W{1'b1}});
    tick(0, 0, 0);
    tick(0, 1, 0);
    // R1: one zero entered stage 1
    chk("R1 stage one input", en_a, {{(W-1){1'b1}}, 1'b0});
    // R10: 64-bit pattern through the chain
    for (int k = 0; k < 2*W; k++) tick(pat[2*W-1-k], 0, 0);
    tick(0, 1, 0);
    chk("R10 head bank", en_a, pat[W-1:0]);
    chk("R10 tail bank", en_b, pat[2*W-1:W]);
    keep_a = en_a; keep_b = en_b;
    // R3 hold while latch_en low
    for (int k = 0; k < 10; k++) tick(k[0], 0, 0);
    chk("R3 hold head", en_a, keep_a);
    chk("R3 hold tail", en_b, keep_b);
    // R6/R7 out_off during shifting
    for (int k = 0; k < W; k++) tick(k[1], 0, 1);
    chk("R6 all released", {en_a, en_b}, 64'h0);
    tick(0, 0, 0);
    chk("R7 hold kept after off", en_a, keep_a);
    tick(0, 1, 0);
    // R4 set in the middle of a stream
    for (int k = 0; k < 20; k++) tick(k[2], 0, 0);
    set_n = 1'b0;
    #1;
    chk("R4 async set head", en_a, {W{1'b1}});
    chk("R4 async cascade", casc_b, 1'b1);
    @(negedge clk); compare();
    set_n = 1'b1;
    for (int k = 0; k < 2*W; k++) tick(pat[k], (k % 7) == 0, (k % 5) == 0);
    // mixed stimulus with occasional set
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:0] == 8'h3C) set_n = 1'b0;
      else set_n = 1'b1;
      tick(lfsr[0], lfsr[3] & lfsr[5], lfsr[9] & lfsr[11] & lfsr[2]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule